// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM With Turnaround-Free Writes

This block models a synchronous static RAM whose read data flows straight from the array to the output in the same cycle in which the address is registered. Every command, address and byte mask is captured on the rising clock edge. Write data arrives one edge later than its address. That one-edge lag lets the bus carry a read and a write in consecutive cycles with no idle cycle between them. A write stays in a pending register for one more edge before it reaches the array. A read of that address in the meantime takes the pending bytes, so it always sees the newest value.

A load cycle (`adv_ld` low) starts a read, a write or a deselect at the external address. A continue cycle (`adv_ld` high) advances a two-bit burst counter over the low address bits, in either linear or interleaved order. Three chip enables must all be active for the device to respond. An active-low clock enable freezes the whole block, and a sleep pin silences it. The bidirectional data bus appears as a separate input, output and drive enable.

Top module: `nwsram_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the deselected state with no pending write, and `dout_en` is low in the following cycle.
- R2: A load cycle selects the device only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination loads a deselect, and `dout_en` stays low.
- R3: A read loaded at an edge drives the addressed word on `dout` in the cycle after that edge. `dout_en` is high in that cycle only while `oe_n` is low, and it follows `oe_n` without waiting for a clock edge.
- R4: Write data is taken from `din` at the edge after the write address. Lane i is `din[9*i+8:9*i]`, and it is written only if `bw_n[i]`=0, with `bw_n` sampled together with the address.
- R5: A read of an address whose write data was taken at the same edge returns the pending lanes merged over the stored lanes.
- R6: Reads and writes may alternate on consecutive edges, in either order, with no idle cycle, and every read returns correct data.
- R7: With `burst_ilv`=0, each continue cycle moves the two low address bits to (start + n) mod 4, and the upper bits keep the value from the load.
- R8: With `burst_ilv`=1, the two low address bits on continue cycle n are (start XOR n).
- R9: While `cke_n` is high, no input is sampled and every register holds its value. The output stays as it was, and a write issued during the suspend has no effect on the array.
- R10: While `sleep` is high, `dout_en` is low at once, every command is treated as a deselect, and the array keeps its contents.
- R11: A continue cycle that follows a deselect remains a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Active-low clock enable; high suspends the block |
| adv_ld | input | 1 | Low loads a new command and address; high continues the burst |
| we_n | input | 1 | Low requests a write on a load cycle |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| bw_n | input | LANES | Active-low per-lane write enables |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Sleep: commands ignored, outputs off |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | AW | Word address |
| din | input | LANES*9 | Write data bus |
| dout | output | LANES*9 | Read data bus |
| dout_en | output | 1 | Drive enable for the shared data bus |

## Verification
The case that needs care is a write's data phase landing at the same edge as a read load of the same address. The array has not taken the bytes yet, and the forwarding path must merge them lane by lane. The bench first writes a full word and then a partial word with two lanes masked to the same address on consecutive edges, and reads that address at the very next edge. The merged word is predicted from the lane map. Strict write/read alternation over different addresses is also run, so that a forward on an address mismatch would be exposed.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

    localparam int LANE_W  = 9;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits for burst step cnt from start position base
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] base,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/nwsram_ctrl.sv
module nwsram_ctrl
    import nwsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sleep,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic             sel,
    input  logic [LANES-1:0] bw_n,
    input  logic [AW-1:0]    addr,
    input  logic             ilv,
    output op_e              op,
    output logic [AW-1:0]    eff_addr,
    output logic [LANES-1:0] lane_mask
);

    op_e                op_q;
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [LANES-1:0]   mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (step) begin
            if (sleep) begin
                op_q   <= OP_IDLE;
                cnt_q  <= '0;
                mask_q <= '0;
            end else if (!adv_ld) begin
                op_q   <= !sel ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
                base_q <= addr;
                cnt_q  <= '0;
                mask_q <= ~bw_n;
            end else if (op_q != OP_IDLE) begin
                cnt_q  <= cnt_q + 1'b1;
                mask_q <= ~bw_n;
            end
        end
    end

    assign op        = op_q;
    assign lane_mask = mask_q;
    assign eff_addr  = {base_q[AW-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, ilv)};

    // R9: suspended edges leave the command state untouched
    a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(op_q) && $stable(base_q) && $stable(cnt_q)));

    // R7: continue cycles never change the loaded upper address
    a_r7_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (step && !sleep && adv_ld) |=> $stable(base_q));

    // R10: sleeping edges load a deselect
    a_r10_sleep_desel: assert property (@(posedge clk) disable iff (rst)
        (step && sleep) |=> (op_q == OP_IDLE));

    // R11: a burst continued from a deselect stays deselected
    a_r11_desel_sticky: assert property (@(posedge clk) disable iff (rst)
        (step && adv_ld && op_q == OP_IDLE) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/nwsram_wpipe.sv
module nwsram_wpipe
    import nwsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sleep,
    input  op_e              op,
    input  logic [AW-1:0]    eff_addr,
    input  logic [LANES-1:0] lane_mask,
    input  logic [DW-1:0]    din,
    output logic             pend_v,
    output logic [AW-1:0]    pend_addr,
    output logic [LANES-1:0] pend_mask,
    output logic [DW-1:0]    pend_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_mask <= '0;
            pend_data <= '0;
        end else if (step) begin
            pend_v <= (op == OP_WRITE) && !sleep;
            if ((op == OP_WRITE) && !sleep) begin
                pend_addr <= eff_addr;
                pend_mask <= lane_mask;
                pend_data <= din;
            end
        end
    end

    // R9: a pending write survives a suspended edge unchanged
    a_r9_pend_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pend_v) && $stable(pend_addr) && $stable(pend_data)));

endmodule

// File: rtl/nwsram_array.sv
module nwsram_array
    import nwsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             wr,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wmask,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr && wmask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/nwsram_top.sv
module nwsram_top
    import nwsram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  logic             sleep,
    input  logic             burst_ilv,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);

    logic             step;
    logic             sel;
    op_e              op;
    logic [AW-1:0]    eff_addr;
    logic [LANES-1:0] lane_mask;
    logic             pend_v;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_mask;
    logic [DW-1:0]    pend_data;
    logic [DW-1:0]    arr_rdata;
    logic             fwd_hit;

    assign step = !cke_n;
    assign sel  = !ce1_n && ce2 && !ce3_n;

    nwsram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .sleep     (sleep),
        .adv_ld    (adv_ld),
        .we_n      (we_n),
        .sel       (sel),
        .bw_n      (bw_n),
        .addr      (addr),
        .ilv       (burst_ilv),
        .op        (op),
        .eff_addr  (eff_addr),
        .lane_mask (lane_mask)
    );

    nwsram_wpipe #(.AW(AW), .LANES(LANES)) u_wpipe (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .sleep     (sleep),
        .op        (op),
        .eff_addr  (eff_addr),
        .lane_mask (lane_mask),
        .din       (din),
        .pend_v    (pend_v),
        .pend_addr (pend_addr),
        .pend_mask (pend_mask),
        .pend_data (pend_data)
    );

    nwsram_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk   (clk),
        .wr    (step && pend_v),
        .waddr (pend_addr),
        .wmask (pend_mask),
        .wdata (pend_data),
        .raddr (eff_addr),
        .rdata (arr_rdata)
    );

    // Pending bytes override stored bytes lane by lane
    assign fwd_hit = pend_v && (pend_addr == eff_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign dout[l*LANE_W +: LANE_W] = (fwd_hit && pend_mask[l])
            ? pend_data[l*LANE_W +: LANE_W]
            : arr_rdata[l*LANE_W +: LANE_W];
    end

    assign dout_en = (op == OP_READ) && !oe_n && !sleep;

    // R1: reset leaves no drive and no pending write
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!dout_en && !pend_v));

    // R2: an unselected load never drives the bus next cycle
    a_r2_unselected: assert property (@(posedge clk) disable iff (rst)
        (step && !sleep && !adv_ld && !sel) |=> !dout_en);

    // R4: a registered write always yields a pending write at the data edge
    a_r4_data_edge: assert property (@(posedge clk) disable iff (rst)
        (step && !sleep && op == OP_WRITE) |=> pend_v);

    // R10: sleep holds the bus released
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (sleep && $past(sleep)) |-> !dout_en);

endmodule

// File: tb/tb_nwsram_top.sv
module tb_nwsram_top;

    localparam int AW    = 8;
    localparam int LANES = 4;
    localparam int DW    = LANES * 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cke_n = 1'b0;
    logic             adv_ld = 1'b0;
    logic             we_n = 1'b1;
    logic             ce1_n = 1'b1;
    logic             ce2 = 1'b0;
    logic             ce3_n = 1'b1;
    logic [LANES-1:0] bw_n = '1;
    logic             oe_n = 1'b0;
    logic             sleep = 1'b0;
    logic             burst_ilv = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    din = '0;
    logic [DW-1:0]    dout;
    logic             dout_en;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    nwsram_top #(.AW(AW), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .burst_ilv(burst_ilv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic          adv;
        logic          we_n;
        logic          sel;
        logic [3:0]    bw_n;
        logic [7:0]    addr;
        logic [35:0]   din;
        logic          exp_en;
        logic [35:0]   exp_d;
    } vec_t;

    localparam logic [35:0] D10 = {9'h103, 9'h102, 9'h101, 9'h100};
    localparam logic [35:0] D11 = {9'h113, 9'h112, 9'h111, 9'h110};
    localparam logic [35:0] D13 = {9'h133, 9'h132, 9'h131, 9'h130};
    localparam logic [35:0] D14 = {9'h143, 9'h142, 9'h141, 9'h140};
    localparam logic [35:0] DF  = {9'h013, 9'h012, 9'h011, 9'h010};
    localparam logic [35:0] DP  = {9'h1F3, 9'h1F2, 9'h1F1, 9'h1F0};
    localparam logic [35:0] DM  = {9'h013, 9'h1F2, 9'h011, 9'h1F0};

    // adv, we_n, sel, bw_n, addr, din, exp_en, exp_d
    localparam vec_t VEC [15] = '{
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h10, 36'h0, 1'b0, 36'h0},  // R4 write addr
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h11, D10,   1'b0, 36'h0},  // R6 W->W
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h10, D11,   1'b1, D10  },  // R6 W->R
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h11, 36'h0, 1'b1, D11  },  // R3
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h12, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b0, 1'b1, 4'b1010, 8'h12, DF,    1'b0, 36'h0},  // R4 lanes 0,2
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h12, DP,    1'b1, DM   },  // R5 merge
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h12, 36'h0, 1'b1, DM   },  // R4 committed
        '{1'b0, 1'b1, 1'b0, 4'b0000, 8'h12, 36'h0, 1'b0, 36'h0},  // R2 deselect
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h10, 36'h0, 1'b1, D10  },
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h13, 36'h0, 1'b0, 36'h0},
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h13, D13,   1'b1, D13  },  // R5 full fwd
        '{1'b0, 1'b0, 1'b1, 4'b0000, 8'h14, 36'h0, 1'b0, 36'h0},  // R6 R->W
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h10, D14,   1'b1, D10  },  // R6 no false fwd
        '{1'b0, 1'b1, 1'b1, 4'b0000, 8'h14, 36'h0, 1'b1, D14  }
    };

    task automatic drive(input logic a, input logic w, input logic c1n,
                         input logic c2, input logic c3n, input logic [3:0] b,
                         input logic [7:0] ad, input logic [35:0] d);
        @(negedge clk);
        adv_ld = a; we_n = w; ce1_n = c1n; ce2 = c2; ce3_n = c3n;
        bw_n = b; addr = ad; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp_en,
                       input logic [35:0] exp_d, input bit use_d);
        checks++;
        if (dout_en !== exp_en || (use_d && dout !== exp_d)) begin
            failures++;
            $display("FAIL %s: dout_en=%b exp=%b dout=%h exp=%h",
                     req, dout_en, exp_en, dout, exp_d);
        end
    endtask

    function automatic logic [35:0] tag(input logic [7:0] a);
        return {28'h0, a};
    endfunction

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog: expired act=1 exp=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset", 1'b0, 36'h0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 15; i++) begin
            drive(VEC[i].adv, VEC[i].we_n, !VEC[i].sel, VEC[i].sel, !VEC[i].sel,
                  VEC[i].bw_n, VEC[i].addr, VEC[i].din);
            chk($sformatf("R6 vector %0d", i), VEC[i].exp_en, VEC[i].exp_d, VEC[i].exp_en);
        end

        // R2: each enable inactive on its own
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R2 ce1_n high", 1'b0, 36'h0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R2 ce2 low", 1'b0, 36'h0, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'h10, 36'h0);
        chk("R2 ce3_n high", 1'b0, 36'h0, 1'b0);

        // R3: output enable acts without a clock edge
        @(negedge clk);
        oe_n = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R3 oe_n high", 1'b0, 36'h0, 1'b0);
        oe_n = 1'b0;
        #1;
        chk("R3 oe_n low async", 1'b1, D10, 1'b1);

        // Fill 0x20..0x23 for bursts
        for (int a = 32; a < 36; a++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'(a),
                  (a == 32) ? 36'h0 : tag(8'(a - 1)));
        end
        // R7: linear burst from 0x22
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h22, tag(8'h23));
        chk("R7 linear step0", 1'b1, tag(8'h22), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R7 linear step1", 1'b1, tag(8'h23), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R7 linear step2", 1'b1, tag(8'h20), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R7 linear step3", 1'b1, tag(8'h21), 1'b1);

        // R8: interleaved burst from 0x21
        @(negedge clk);
        burst_ilv = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h21, 36'h0);
        chk("R8 ilv step0", 1'b1, tag(8'h21), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R8 ilv step1", 1'b1, tag(8'h20), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R8 ilv step2", 1'b1, tag(8'h23), 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h00, 36'h0);
        chk("R8 ilv step3", 1'b1, tag(8'h22), 1'b1);
        @(negedge clk);
        burst_ilv = 1'b0;

        // R11: continue after deselect stays deselected
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R11 continue 1", 1'b0, 36'h0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R11 continue 2", 1'b0, 36'h0, 1'b0);

        // R9: suspend freezes output and blocks writes
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        @(negedge clk);
        cke_n = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 36'h0);
        chk("R9 output held", 1'b1, D10, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 36'hF_FFFF_FFFF);
        chk("R9 still held", 1'b1, D10, 1'b1);
        @(negedge clk);
        cke_n = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h10, 36'h0);
        chk("R9 no write", 1'b1, D10, 1'b1);

        // R10: sleep silences the bus and ignores commands
        @(negedge clk);
        sleep = 1'b1;
        #1;
        chk("R10 immediate off", 1'b0, 36'h0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 36'h0);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 36'hA_AAAA_AAAA);
        chk("R10 off in sleep", 1'b0, 36'h0, 1'b0);
        @(negedge clk);
        sleep = 1'b0;
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 8'h11, 36'h0);
        chk("R10 array kept", 1'b1, D11, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule